// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns a stream of stereo sample pairs into a serial audio link. It is the clock master. It drives a bit clock, a frame clock and one data line, and it derives all three from a single-cycle enable tick. Each tick is one half period of the bit clock. A sample pair is offered on a parallel holding interface as two 32-bit words. The audio sits left-aligned in each word, so a 16-bit sample occupies bits 31:16. The pair is taken once per frame, at the frame start.

A static configuration selects how each frame is laid out. Justified modes place one sample per half frame, with the frame clock as a square wave. PCM mode sends both samples back to back after a one-bit-clock frame strobe. A bit-clock offset moves the first data bit later. With it, classic I2S framing is justified mode with offset 1, DSP-A is PCM mode with offset 1, and DSP-B is PCM mode with offset 0. The half-frame length and both clock polarities can also be set. If no sample pair is ready at a frame start, the block transmits silence and raises a sticky underrun flag, which is cleared by a write of 1.

Top module: `sfx_tx`

## Requirements
- R1: After reset, and whenever `glb_en` and `tx_en` are not both 1, the outputs rest at: `ser_bclk` = `cfg_bclk_inv`, `ser_fclk` = `cfg_fclk_inv`, `ser_data` = 0 and `smp_ready` = 0. `urun_flag` is 0 after reset.
- R2: While running, each `bclk_tick` toggles the internal bit clock, and the first toggle after enabling is a rising edge. `ser_bclk` is the internal clock XOR `cfg_bclk_inv`. Frame position and data advance only on internal falling edges. The first falling edge starts frame position 0.
- R3: A half frame lasts `cfg_half_m1`+1 bit clocks and a frame lasts twice that. In the justified modes, `ser_fclk` equals `cfg_fclk_inv` during the first (left) half and its inverse during the second (right) half.
- R4: When `cfg_mode` = 0 (PCM), `ser_fclk` is the inverse of `cfg_fclk_inv` for exactly frame position 0 and equals `cfg_fclk_inv` elsewhere. The left sample goes out MSB first starting at frame position `cfg_offset`. The right sample follows directly, and all other positions carry 0.
- R5: When `cfg_mode` = 1 (left-justified), each half sends its own sample MSB first, starting at the half-frame position `cfg_offset`. The left sample goes in the first half and the right in the second. All other positions carry 0.
- R6: When `cfg_mode` = 2 (right-justified), the sample LSB falls on the last bit clock of each half and earlier positions carry 0. `cfg_offset` has no effect in this mode.
- R7: The transmitted sample is bits 31:16 of `smp_left` and `smp_right`. Bits 15:0 have no effect on `ser_data`.
- R8: `smp_ready` is 1 for one clock in the cycle whose tick makes the falling edge that begins a frame. The words on the sample inputs are taken in that cycle if `smp_valid` is 1.
- R9: If `smp_valid` is 0 when `smp_ready` is 1, that frame carries only zeros and `urun_flag` becomes 1. The flag stays 1 until a clock with `urun_clr` = 1. A new underrun in the same clock as a clear leaves the flag at 1.
- R10: With `dout_en` = 0, `ser_data` is 0 while both clocks keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | Single-cycle strobe; one per bit-clock half period |
| glb_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| dout_en | input | 1 | Allows data onto `ser_data` |
| cfg_mode | input | 2 | 0 PCM, 1 left-justified, 2 right-justified |
| cfg_offset | input | 2 | Data delay in bit clocks (PCM and left-justified) |
| cfg_half_m1 | input | 8 | Bit clocks per half frame minus one |
| cfg_bclk_inv | input | 1 | Inverts the bit clock |
| cfg_fclk_inv | input | 1 | Inverts the frame clock |
| smp_valid | input | 1 | A sample pair is on offer |
| smp_left | input | 32 | Left word, audio left-aligned |
| smp_right | input | 32 | Right word, audio left-aligned |
| smp_ready | output | 1 | Pair taken at this frame start |
| urun_clr | input | 1 | Write 1 to clear the underrun flag |
| urun_flag | output | 1 | Sticky underrun indicator |
| ser_bclk | output | 1 | Serial bit clock |
| ser_fclk | output | 1 | Serial frame clock |
| ser_data | output | 1 | Serial data |

## Verification
Each frame layout is driven with sample pairs whose left and right bit patterns differ and are asymmetric. A misplaced offset, a swapped channel or a reversed bit order therefore shows up as a wrong bit at a known position. One run uses a half frame exactly as long as the sample. The right-justified runs use a longer half frame with two different offsets, so they can show that the offset is ignored. Words with nonzero low halves separate the sample field from the unused bits. Inverted polarities are mixed into both justified and PCM runs. Separate runs with data muted and with no sample on offer test the gating, the zero fill and the flag's set and clear ordering.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    typedef enum logic [1:0] {
        FMT_PCM = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

endpackage

// File: rtl/sfx_bclk_gen.sv
module sfx_bclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic bclk_raw,
    output logic fall_stb
);

    typedef struct packed {
        logic phase;
    } bclk_st_t;

    bclk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.phase = 1'b0;
        end else if (tick) begin
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_raw = st_q.phase;
    assign fall_stb = run & tick & st_q.phase;

    AST_BCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bclk_raw); // R1
    AST_BCLK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick |=> bclk_raw != $past(bclk_raw)); // R2
    AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick |=> $stable(bclk_raw)); // R2

endmodule

// File: rtl/sfx_frame_seq.sv
module sfx_frame_seq #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fall_stb,
    input  logic [HALF_W-1:0] half_m1,
    output logic              active,
    output logic              frame_start,
    output logic              second_half,
    output logic [HALF_W:0]   fpos,
    output logic [HALF_W:0]   pos,
    output logic [HALF_W:0]   half_len
);

    typedef struct packed {
        logic            active;
        logic [HALF_W:0] fpos;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [HALF_W:0] last_pos;
    logic [HALF_W:0] step_one;

    assign step_one = {{HALF_W{1'b0}}, 1'b1};
    assign half_len = {1'b0, half_m1} + step_one;
    assign last_pos = {half_m1, 1'b1};

    always_comb begin
        frame_start = fall_stb & (~st_q.active | (st_q.fpos == last_pos));
        st_d = st_q;
        if (!run) begin
            st_d.active = 1'b0;
            st_d.fpos   = '0;
        end else if (fall_stb) begin
            st_d.active = 1'b1;
            st_d.fpos   = frame_start ? '0 : st_q.fpos + step_one;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active      = st_q.active;
    assign fpos        = st_q.fpos;
    assign second_half = st_q.fpos >= half_len;
    assign pos         = second_half ? st_q.fpos - half_len : st_q.fpos;

    AST_FPOS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> fpos <= last_pos); // R3
    AST_FPOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run && active && !fall_stb |=> $stable(fpos)); // R2

endmodule

// File: rtl/sfx_slot_data.sv
module sfx_slot_data
    import sfx_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int HALF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    input  logic             urun_clr,
    input  logic [1:0]       mode,
    input  logic [1:0]       offset,
    input  logic [HALF_W:0]  fpos,
    input  logic [HALF_W:0]  pos,
    input  logic [HALF_W:0]  half_len,
    input  logic             second_half,
    output logic             data_bit,
    output logic             urun
);

    localparam int IDX_W = $clog2(SMP_W);

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
        logic             urun;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic [SMP_W-1:0] half_smp;
    int k_lead;
    int k_tail;

    always_comb begin
        st_d = st_q;
        if (urun_clr) st_d.urun = 1'b0;
        if (frame_start) begin
            if (smp_valid) begin
                st_d.left  = smp_left;
                st_d.right = smp_right;
            end else begin
                st_d.left  = '0;
                st_d.right = '0;
                st_d.urun  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        data_bit = 1'b0;
        half_smp = second_half ? st_q.right : st_q.left;
        k_lead   = 0;
        k_tail   = 0;
        case (fmt_e'(mode))
            FMT_PCM: begin
                k_lead = int'(fpos) - int'(offset);
                if (k_lead >= 0 && k_lead < SMP_W) begin
                    data_bit = st_q.left[IDX_W'(SMP_W - 1 - k_lead)];
                end else if (k_lead >= SMP_W && k_lead < 2 * SMP_W) begin
                    data_bit = st_q.right[IDX_W'(2 * SMP_W - 1 - k_lead)];
                end
            end
            FMT_LJ: begin
                k_lead = int'(pos) - int'(offset);
                if (k_lead >= 0 && k_lead < SMP_W) begin
                    data_bit = half_smp[IDX_W'(SMP_W - 1 - k_lead)];
                end
            end
            FMT_RJ: begin
                k_tail = int'(half_len) - 1 - int'(pos);
                if (k_tail >= 0 && k_tail < SMP_W) begin
                    data_bit = half_smp[IDX_W'(k_tail)];
                end
            end
            default: data_bit = 1'b0;
        endcase
    end

    assign urun = st_q.urun;

    AST_URUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && !smp_valid |=> urun); // R9
    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        urun && !urun_clr |=> urun); // R9
    AST_URUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urun) |-> $past(frame_start && !smp_valid)); // R9

endmodule

// File: rtl/sfx_tx.sv
module sfx_tx
    import sfx_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int WORD_W = 32,
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_tick,
    input  logic              glb_en,
    input  logic              tx_en,
    input  logic              dout_en,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_offset,
    input  logic [HALF_W-1:0] cfg_half_m1,
    input  logic              cfg_bclk_inv,
    input  logic              cfg_fclk_inv,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_left,
    input  logic [WORD_W-1:0] smp_right,
    output logic              smp_ready,
    input  logic              urun_clr,
    output logic              urun_flag,
    output logic              ser_bclk,
    output logic              ser_fclk,
    output logic              ser_data
);

    logic            run;
    logic            bclk_raw;
    logic            fall_stb;
    logic            active;
    logic            frame_start;
    logic            second_half;
    logic            data_bit;
    logic            fclk_raw;
    logic [HALF_W:0] fpos;
    logic [HALF_W:0] pos;
    logic [HALF_W:0] half_len;

    assign run = glb_en & tx_en;

    generate
        if (WORD_W > SMP_W) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^{smp_left[WORD_W-SMP_W-1:0], smp_right[WORD_W-SMP_W-1:0]};
        end
    endgenerate

    sfx_bclk_gen u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (bclk_tick),
        .bclk_raw (bclk_raw),
        .fall_stb (fall_stb)
    );

    sfx_frame_seq #(.HALF_W(HALF_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .fall_stb    (fall_stb),
        .half_m1     (cfg_half_m1),
        .active      (active),
        .frame_start (frame_start),
        .second_half (second_half),
        .fpos        (fpos),
        .pos         (pos),
        .half_len    (half_len)
    );

    sfx_slot_data #(.SMP_W(SMP_W), .HALF_W(HALF_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .smp_valid   (smp_valid),
        .smp_left    (smp_left[WORD_W-1 -: SMP_W]),
        .smp_right   (smp_right[WORD_W-1 -: SMP_W]),
        .urun_clr    (urun_clr),
        .mode        (cfg_mode),
        .offset      (cfg_offset),
        .fpos        (fpos),
        .pos         (pos),
        .half_len    (half_len),
        .second_half (second_half),
        .data_bit    (data_bit),
        .urun        (urun_flag)
    );

    always_comb begin
        fclk_raw = 1'b0;
        if (active) begin
            if (fmt_e'(cfg_mode) == FMT_PCM) fclk_raw = (fpos == '0);
            else                             fclk_raw = second_half;
        end
    end

    assign smp_ready = frame_start;
    assign ser_bclk  = bclk_raw ^ cfg_bclk_inv;
    assign ser_fclk  = fclk_raw ^ cfg_fclk_inv;
    assign ser_data  = active & dout_en & data_bit;

    AST_DATA_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> !ser_data); // R10
    AST_READY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !(ser_bclk ^ cfg_bclk_inv)); // R8
    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> active && fpos == '0); // R3

endmodule

// File: tb/tb_sfx_tx.sv
module tb_sfx_tx;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bclk_tick;
    logic        glb_en, tx_en, dout_en;
    logic [1:0]  cfg_mode, cfg_offset;
    logic [7:0]  cfg_half_m1;
    logic        cfg_bclk_inv, cfg_fclk_inv;
    logic        smp_valid;
    logic [31:0] smp_left, smp_right;
    logic        smp_ready;
    logic        urun_clr, urun_flag;
    logic        ser_bclk, ser_fclk, ser_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sfx_tx dut (
        .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick),
        .glb_en(glb_en), .tx_en(tx_en), .dout_en(dout_en),
        .cfg_mode(cfg_mode), .cfg_offset(cfg_offset), .cfg_half_m1(cfg_half_m1),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_fclk_inv(cfg_fclk_inv),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .smp_ready(smp_ready), .urun_clr(urun_clr), .urun_flag(urun_flag),
        .ser_bclk(ser_bclk), .ser_fclk(ser_fclk), .ser_data(ser_data)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  off;
        logic [7:0]  hm1;
        logic        binv;
        logic        finv;
        logic [31:0] l;
        logic [31:0] r;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd1, 8'd31, 1'b0, 1'b0, 32'hA5C3_0000, 32'h3C5A_0000}, // R5 I2S framing
        '{2'd1, 2'd0, 8'd15, 1'b1, 1'b1, 32'h8001_FFFF, 32'h7FFE_1234}, // R5 R7 low bits set
        '{2'd2, 2'd0, 8'd23, 1'b0, 1'b0, 32'hF00D_0000, 32'h1248_0000}, // R6
        '{2'd2, 2'd2, 8'd23, 1'b0, 1'b1, 32'hF00D_0000, 32'h1248_0000}, // R6 offset ignored
        '{2'd0, 2'd1, 8'd31, 1'b0, 1'b0, 32'hC001_0000, 32'h0FF0_0000}, // R4 DSP-A
        '{2'd0, 2'd0, 8'd19, 1'b1, 1'b1, 32'hB2E7_5555, 32'h6D19_AAAA}  // R4 DSP-B
    };

    task automatic chk(input logic ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input vec_t v, input int fp);
        int h, p, k;
        logic ch;
        logic [15:0] sl, sr, s, tmp;
        h  = int'(v.hm1) + 1;
        ch = (fp >= h);
        p  = ch ? fp - h : fp;
        sl = v.l[31:16];
        sr = v.r[31:16];
        s  = ch ? sr : sl;
        tmp = '0;
        case (v.mode)
            2'd0: begin
                k = fp - int'(v.off);
                if (k >= 0 && k < 16) tmp = sl >> (15 - k);
                else if (k >= 16 && k < 32) tmp = sr >> (31 - k);
            end
            2'd1: begin
                k = p - int'(v.off);
                if (k >= 0 && k < 16) tmp = s >> (15 - k);
            end
            2'd2: begin
                k = h - 1 - p;
                if (k >= 0 && k < 16) tmp = s >> k;
            end
            default: tmp = '0;
        endcase
        return tmp[0];
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Enables the link with vector v, checks every falling-edge bit for nframes
    task automatic run_vec(input vec_t v, input logic dout, input logic valid,
                           input int nframes);
        int h, flen, n, guard, rdy, last_fall, fp;
        logic prev, raw, eb, ef;
        string rq;
        h = int'(v.hm1) + 1;
        flen = 2 * h;
        rq = (v.mode == 2'd0) ? "R4" : (v.mode == 2'd1) ? "R5" : "R6";
        if (!dout) rq = "R10";
        if (!valid) rq = "R9";
        @(negedge clk);
        tx_en = 1'b0;
        glb_en = 1'b1;
        dout_en = dout;
        cfg_mode = v.mode;
        cfg_offset = v.off;
        cfg_half_m1 = v.hm1;
        cfg_bclk_inv = v.binv;
        cfg_fclk_inv = v.finv;
        smp_valid = valid;
        smp_left = v.l;
        smp_right = v.r;
        repeat (3) @(negedge clk);
        tx_en = 1'b1;
        prev = 1'b0;
        n = 0; guard = 0; rdy = 0; last_fall = 0;
        while (n < nframes * flen && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (smp_ready) rdy++;
            raw = ser_bclk ^ v.binv;
            if (prev && !raw) begin
                fp = n % flen;
                eb = valid & dout & exp_bit(v, fp);
                ef = ((v.mode == 2'd0) ? (fp == 0) : (fp >= h)) ^ v.finv;
                chk(ser_data === eb, rq, "data bit", int'(ser_data), int'(eb));
                chk(ser_fclk === ef, (v.mode == 2'd0) ? "R4" : "R3", "frame clock",
                    int'(ser_fclk), int'(ef));
                if (n > 0) chk(guard - last_fall == 4, "R2", "bit clock period",
                               guard - last_fall, 4);
                last_fall = guard;
                n++;
            end
            prev = raw;
        end
        if (guard >= 20000) chk(1'b0, "R2", "falling edges seen", n, nframes * flen);
        chk(rdy == nframes, "R8", "ready pulses", rdy, nframes);
        tx_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        bclk_tick = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            bclk_tick = ~bclk_tick;
        end
    end

    initial begin
        #1500000;
        chk(1'b0, "R2", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        glb_en = 1'b0; tx_en = 1'b0; dout_en = 1'b0;
        cfg_mode = 2'd1; cfg_offset = 2'd0; cfg_half_m1 = 8'd31;
        cfg_bclk_inv = 1'b0; cfg_fclk_inv = 1'b0;
        smp_valid = 1'b0; smp_left = '0; smp_right = '0; urun_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk(ser_bclk == 1'b0, "R1", "bclk after reset", int'(ser_bclk), 0);
        chk(ser_fclk == 1'b0, "R1", "fclk after reset", int'(ser_fclk), 0);
        chk(ser_data == 1'b0, "R1", "data after reset", int'(ser_data), 0);
        chk(urun_flag == 1'b0, "R1", "underrun after reset", int'(urun_flag), 0);
        chk(smp_ready == 1'b0, "R1", "ready after reset", int'(smp_ready), 0);

        // R1: idle levels follow polarity when only one enable is set
        cfg_bclk_inv = 1'b1; cfg_fclk_inv = 1'b1; dout_en = 1'b1;
        smp_valid = 1'b1; smp_left = 32'hFFFF_0000; smp_right = 32'hFFFF_0000;
        glb_en = 1'b1; tx_en = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(ser_bclk == 1'b1 && ser_fclk == 1'b1 && ser_data == 1'b0 && smp_ready == 1'b0,
                "R1", "idle with tx off", int'({ser_bclk, ser_fclk, ser_data}), 6);
        end
        glb_en = 1'b0; tx_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(ser_bclk == 1'b1 && ser_fclk == 1'b1 && ser_data == 1'b0 && smp_ready == 1'b0,
                "R1", "idle with global off", int'({ser_bclk, ser_fclk, ser_data}), 6);
        end
        tx_en = 1'b0;

        // Table: every framing mode and polarity mix
        for (int vi = 0; vi < NV; vi++) begin
            run_vec(VECS[vi], 1'b1, 1'b1, 2);
        end

        // R10: muted data, clocks unchanged
        run_vec(VECS[0], 1'b0, 1'b1, 1);
        run_vec(VECS[5], 1'b0, 1'b1, 1);

        // R9: underrun fills zeros and sets a sticky flag
        chk(urun_flag == 1'b0, "R9", "flag clear before underrun", int'(urun_flag), 0);
        run_vec(VECS[4], 1'b1, 1'b0, 1);
        chk(urun_flag == 1'b1, "R9", "flag after underrun", int'(urun_flag), 1);
        run_vec(VECS[0], 1'b1, 1'b1, 1);
        chk(urun_flag == 1'b1, "R9", "flag sticky over good frames", int'(urun_flag), 1);
        urun_clr = 1'b1;
        @(negedge clk);
        urun_clr = 1'b0;
        chk(urun_flag == 1'b0, "R9", "flag after clear", int'(urun_flag), 0);

        // R9: set wins over a clear in the same clock
        smp_valid = 1'b0;
        urun_clr = 1'b1;
        tx_en = 1'b1;
        begin
            int g;
            g = 0;
            while (!smp_ready && g < 1000) begin
                @(negedge clk);
                g++;
            end
            chk(g < 1000, "R8", "ready seen for set-wins test", g, 0);
        end
        @(negedge clk);
        chk(urun_flag == 1'b1, "R9", "set wins over clear", int'(urun_flag), 1);
        @(negedge clk);
        chk(urun_flag == 1'b0, "R9", "held clear takes effect", int'(urun_flag), 0);
        urun_clr = 1'b0;
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(ser_bclk == cfg_bclk_inv && ser_fclk == cfg_fclk_inv && ser_data == 1'b0,
            "R1", "idle after disable", int'({ser_bclk, ser_fclk, ser_data}),
            int'({cfg_bclk_inv, cfg_fclk_inv, 1'b0}));

        summary();
        $finish;
    end

endmodule